// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter Stage

A synchronous up-counter slice of parameterised width (four bits by default). It is meant to be chained into wider counters. Every bit of state changes on the rising clock edge. An active-low synchronous clear zeroes the count. An active-low synchronous load copies a data word into the count. When neither is active, the count advances only while both enables are high: a parallel enable `en_p_i` and a trickle enable `en_t_i`.

The terminal-count output `tc_o` is combinational. It is high while the count is all ones and the trickle enable is high. To build a wider counter, feed each stage's `tc_o` into the next stage's `en_t_i` and drive every stage's `en_p_i` from one common enable. To shorten the count cycle, decode a count value and drive the clear low with it: decoding value N gives a cycle of N+1 states with no glitch. A separate asynchronous reset `rst_ni` puts the register in a known state at power-up.

Top module: `bin_count_stage`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0, independent of the clock.
- R2: With `clr_ni` low at a rising edge, `count_o` becomes 0 after that edge, whatever `load_ni`, `en_p_i`, `en_t_i` and `data_i` are.
- R3: With `clr_ni` high and `load_ni` low at a rising edge, `count_o` takes `data_i` after that edge, whatever both enables are.
- R4: With `clr_ni` and `load_ni` high and both enables high, `count_o` increases by one at the rising edge.
- R5: With `clr_ni` and `load_ni` high and either enable low, `count_o` keeps its value.
- R6: An enabled increment from the all-ones value gives 0.
- R7: `tc_o` is high exactly when `en_t_i` is high and `count_o` is all ones. It follows those inputs in the same cycle, including right after a load of all ones.
- R8: Stages chained through `tc_o` to `en_t_i`, with a common `en_p_i`, count as a single counter of the combined width. The last stage's `tc_o` marks the combined all-ones state.
- R9: Driving `clr_ni` from a decode of count value N makes the stage cycle through 0..N, a cycle of N+1 states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_ni | input | 1 | Synchronous clear, active low, highest priority |
| load_ni | input | 1 | Synchronous parallel load, active low |
| en_p_i | input | 1 | Parallel count enable |
| en_t_i | input | 1 | Trickle count enable; also gates `tc_o` |
| data_i | input | WIDTH | Value loaded when `load_ni` is low |
| count_o | output | WIDTH | Current count |
| tc_o | output | 1 | Terminal count: all ones while `en_t_i` is high |

## Verification
A single stage is driven with random mixes of clear, load and the two enables, often with several of them active together. This shows whether the priority between clear, load and the enables is right, and whether the terminal flag depends on the trickle enable alone. Directed runs cover the wrap from all ones, a load of all ones with the trickle enable high, and a hold with each enable low on its own. A chain of three stages is checked against one twelve-bit instance and against a behavioural model. Any error in carry propagation between stages shows up as a mismatch. A stage whose clear is driven from a decode of nine must cycle through exactly ten states, which confirms that the clear acts synchronously.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_LOAD = 2'd2,
    OP_CLR  = 2'd3
  } bcs_op_e;
endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
(
  input  logic    clr_ni,
  input  logic    load_ni,
  input  logic    en_p_i,
  input  logic    en_t_i,
  output bcs_op_e op_o
);
  // clear > load > count > hold
  always_comb begin
    if (!clr_ni)                op_o = OP_CLR;
    else if (!load_ni)          op_o = OP_LOAD;
    else if (en_p_i && en_t_i)  op_o = OP_INC;
    else                        op_o = OP_HOLD;
  end
endmodule

// File: rtl/bcs_next.sv
module bcs_next
  import bcs_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  bcs_op_e          op_i,
  input  logic [WIDTH-1:0] cnt_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] nxt_o
);
  logic [WIDTH-1:0] tog;
  logic [WIDTH-1:0] inc;

  // look-ahead toggle: bit i flips when all lower bits are ones
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign tog[i] = 1'b1;
    end else begin : g_up
      assign tog[i] = &cnt_i[i-1:0];
    end
    assign inc[i] = cnt_i[i] ^ tog[i];
  end

  always_comb begin
    unique case (op_i)
      OP_CLR:  nxt_o = '0;
      OP_LOAD: nxt_o = data_i;
      OP_INC:  nxt_o = inc;
      default: nxt_o = cnt_i;
    endcase
  end
endmodule

// File: rtl/bcs_tc.sv
module bcs_tc #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             en_t_i,
  output logic             tc_o
);
  // combinational so the next stage sees it this cycle
  assign tc_o = en_t_i & (&cnt_i);
endmodule

// File: rtl/bin_count_stage.sv
module bin_count_stage
  import bcs_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             load_ni,
  input  logic             en_p_i,
  input  logic             en_t_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o
);
  localparam logic [WIDTH-1:0] CntMax = {WIDTH{1'b1}};

  bcs_op_e          op;
  logic [WIDTH-1:0] cnt_q, cnt_d;

  bcs_ctrl u_ctrl (
    .clr_ni  (clr_ni),
    .load_ni (load_ni),
    .en_p_i  (en_p_i),
    .en_t_i  (en_t_i),
    .op_o    (op)
  );

  bcs_next #(.WIDTH(WIDTH)) u_next (
    .op_i   (op),
    .cnt_i  (cnt_q),
    .data_i (data_i),
    .nxt_o  (cnt_d)
  );

  bcs_tc #(.WIDTH(WIDTH)) u_tc (
    .cnt_i  (cnt_q),
    .en_t_i (en_t_i),
    .tc_o   (tc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  // R1
  always_comb begin
    if (!rst_ni) reset_zero_chk: assert (count_o == '0);
  end

  // R2
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> count_o == '0);

  // R3
  load_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && !load_ni |=> count_o == $past(data_i));

  // R4
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && load_ni && en_p_i && en_t_i |=> count_o == WIDTH'($past(count_o) + 1'b1));

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && load_ni && !(en_p_i && en_t_i) |=> $stable(count_o));

  // R6
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && load_ni && en_p_i && en_t_i && count_o == CntMax |=> count_o == '0);

  // R7
  tc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_t_i |-> !tc_o);

  // R7
  tc_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_t_i && count_o == CntMax |-> tc_o);
endmodule

// File: tb/bin_count_stage_tb.sv
module bin_count_stage_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic rst_ni = 1'b0;

  // single stage
  logic       clr_n = 1'b1, load_n = 1'b1, ep = 1'b0, et = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] cnt;
  logic       tc;

  bin_count_stage #(.WIDTH(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .clr_ni(clr_n), .load_ni(load_n),
    .en_p_i(ep), .en_t_i(et), .data_i(din), .count_o(cnt), .tc_o(tc)
  );

  // three-stage chain and a wide reference instance
  logic        c_clr_n = 1'b1, c_load_n = 1'b1, c_ep = 1'b0, c_et = 1'b0;
  logic [11:0] c_din = '0;
  logic [3:0]  c0, c1, c2;
  logic        t0, t1, t2;
  logic [11:0] w_cnt;
  logic        w_tc;

  bin_count_stage #(.WIDTH(4)) u_c0 (
    .clk_i(clk), .rst_ni(rst_ni), .clr_ni(c_clr_n), .load_ni(c_load_n),
    .en_p_i(c_ep), .en_t_i(c_et), .data_i(c_din[3:0]), .count_o(c0), .tc_o(t0));
  bin_count_stage #(.WIDTH(4)) u_c1 (
    .clk_i(clk), .rst_ni(rst_ni), .clr_ni(c_clr_n), .load_ni(c_load_n),
    .en_p_i(c_ep), .en_t_i(t0), .data_i(c_din[7:4]), .count_o(c1), .tc_o(t1));
  bin_count_stage #(.WIDTH(4)) u_c2 (
    .clk_i(clk), .rst_ni(rst_ni), .clr_ni(c_clr_n), .load_ni(c_load_n),
    .en_p_i(c_ep), .en_t_i(t1), .data_i(c_din[11:8]), .count_o(c2), .tc_o(t2));
  bin_count_stage #(.WIDTH(12)) u_wide (
    .clk_i(clk), .rst_ni(rst_ni), .clr_ni(c_clr_n), .load_ni(c_load_n),
    .en_p_i(c_ep), .en_t_i(c_et), .data_i(c_din), .count_o(w_cnt), .tc_o(w_tc));

  // modulo-10 stage: clear from decode of 9
  logic [3:0] m_cnt;
  logic       m_tc;
  logic       m_clr_n;
  assign m_clr_n = (m_cnt != 4'd9);

  bin_count_stage #(.WIDTH(4)) u_mod (
    .clk_i(clk), .rst_ni(rst_ni), .clr_ni(m_clr_n), .load_ni(1'b1),
    .en_p_i(1'b1), .en_t_i(1'b1), .data_i(4'd0), .count_o(m_cnt), .tc_o(m_tc));

  // behavioural models
  int    sm = 0, cm = 0, mm = 0;
  string s_req = "R1";

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sm = 0; cm = 0; mm = 0; s_req = "R1";
    end else begin
      if (!clr_n)          begin sm = 0;          s_req = "R2"; end
      else if (!load_n)    begin sm = int'(din);  s_req = "R3"; end
      else if (ep && et)   begin s_req = (sm == 15) ? "R6" : "R4"; sm = (sm + 1) % 16; end
      else                 s_req = "R5";

      if (!c_clr_n)           cm = 0;
      else if (!c_load_n)     cm = int'(c_din);
      else if (c_ep && c_et)  cm = (cm + 1) % 4096;

      mm = (mm == 9) ? 0 : mm + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(int'(cnt) == sm, s_req, int'(cnt), sm);
    chk(tc == (et && sm == 15), "R7", int'(tc), int'(et && sm == 15));
    chk(int'({c2, c1, c0}) == cm, "R8", int'({c2, c1, c0}), cm);
    chk(int'(w_cnt) == cm, "R8", int'(w_cnt), cm);
    chk(t2 == (c_et && cm == 4095), "R8", int'(t2), int'(c_et && cm == 4095));
    chk(w_tc == t2, "R8", int'(w_tc), int'(t2));
    chk(int'(m_cnt) == mm, "R9", int'(m_cnt), mm);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic drive(input logic c, input logic l, input logic p, input logic t, input logic [3:0] d);
    clr_n = c; load_n = l; ep = p; et = t; din = d;
  endtask

  initial begin
    c_ep = 1'b1; c_et = 1'b1;
    // R1: reset state, including with a clock running
    repeat (3) step();
    @(negedge clk);
    rst_ni = 1'b1;

    // R4/R6: free count through a wrap
    drive(1, 1, 1, 1, 4'h0);
    repeat (20) step();
    // R5: each enable low on its own
    drive(1, 1, 0, 1, 4'h0); repeat (3) step();
    drive(1, 1, 1, 0, 4'h0); repeat (3) step();
    // R3/R7: load all ones with trickle high, flag in next cycle
    drive(1, 0, 0, 1, 4'hF); step();
    drive(1, 1, 0, 1, 4'h0); step();
    // R7: trickle low masks the flag at all ones
    drive(1, 1, 1, 0, 4'h0); step();
    // R3: load ignores enables low
    drive(1, 0, 0, 0, 4'h6); step();
    // R2: clear beats load and enables
    drive(0, 0, 1, 1, 4'hA); step();

    // R8: chain near the top of its range
    c_din = 12'd4090; c_load_n = 1'b0;
    drive(1, 1, 1, 1, 4'h0);
    step();
    c_load_n = 1'b1;

    for (int i = 0; i < 6000; i++) begin
      drive($urandom_range(0, 15) != 0, $urandom_range(0, 7) != 0,
            $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
            4'($urandom_range(0, 15)));
      c_ep     = $urandom_range(0, 7) != 0;
      c_et     = $urandom_range(0, 15) != 0;
      c_load_n = $urandom_range(0, 499) != 0;
      c_din    = 12'($urandom_range(4000, 4095));
      c_clr_n  = (i != 3000);
      step();
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule